// File: doc/BRIEF.md
# Programmer Command Dispatcher

This block sits between a byte-wide UART receiver/transmitter pair and a serial-programming frame engine. It takes a stream of single-letter commands from a host, collects any operand bytes, and holds the selected target type and a 16-bit target address. It then either answers locally (identification, versions, supported target list, programmer kind) or sequences one or more frame requests to the engine. Any data the engine returns is forwarded to the host.

Every response byte passes through a small output queue in front of the transmitter. The next command is taken only once the queue has drained. A command that returns no data ends with a carriage return. A command that is unknown, or that the selected target does not allow, ends with a question mark. The engine is reached through a request that is held until acknowledged.

Top module: `prog_cmd_dispatch`

## Requirements
- R1: After reset, rx_ready is 1, tx_valid is 0 and req_valid is 0. The stored target code is 0x00, which is not supported.
- R2: While waiting for a command letter, a received 0x1B byte is dropped. It causes no output and no request, and the next byte is decoded as a command.
- R3: A command that completes without returning data answers exactly one byte, 0x0D. An unknown letter (for example 'F') answers exactly one byte, 0x3F.
- R4: 'A' takes two operand bytes, high byte first, and loads them as the 16-bit address used by later requests. It answers 0x0D.
- R5: 'T' takes one operand byte, stores it as the target code, and answers 0x0D.
- R6: 'V' answers 0x32 0x30 and 'v' answers 0x31 0x30, i.e. 0x30 plus the major number and then 0x30 plus the minor number.
- R7: 't' answers 0x12 0x13 0x20 0x28 0x38 0x48 0x86 0x00. 'p' answers 'S' (0x53). 'S' answers the 7 characters "CMDPROG".
- R8: 'x' and 'y' each consume exactly one operand byte and answer only 0x0D. That operand byte is never decoded as a command, even if it is a letter or 0x1B.
- R9: Engine commands are refused with 0x3F, and issue no request, unless the target code is one of 0x12, 0x13, 0x20, 0x28, 0x38, 0x40, 0x41, 0x48, 0x86. Operands are still consumed first.
- R10: Each engine command issues a request with req_dev set to the target code. The op codes are 'P'=0, 'L'=1, 'c'=2, 'C'=3, 'm'=6, 'D'=7, 'd'=8, 'e'=9, 'l'=10. A one-operand command carries its operand in req_data[7:0]. Commands without return data answer 0x0D after the acknowledge.
- R11: 'C' (op 3) increments the address by one after its frame completes. 'c' (op 2) leaves the address unchanged.
- R12: 'R' issues op 5 and then op 4 at the same address, returns both engine bytes in that order with no 0x0D, and then increments the address. If the target is 0x86, 'R' issues only op 4, returns one byte and does not increment. 'd' (op 8) returns one byte and does not increment.
- R13: 's' issues three op-11 requests with req_data 2, 1, 0 and returns the three bytes in that order. ':' takes three operands into req_data[23:0] (first byte highest), issues op 12, and returns its byte followed by 0x0D. 'C' and 's' are refused with 0x3F when the target is 0x86.
- R14: rx_ready stays 0 while any response byte is queued or a frame is pending. A request holds op, address and data stable until eng_ack. tx_data holds while tx_valid waits for tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Dispatcher takes rx_data this cycle |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes tx_data this cycle |
| req_valid | output | 1 | Frame request pending |
| req_op | output | 4 | Frame operation code |
| req_dev | output | 8 | Selected target code |
| req_addr | output | ADDR_W | Current target address |
| req_data | output | 24 | Operand payload or signature index |
| eng_ack | input | 1 | Engine finished the pending frame |
| eng_rdata | input | 8 | Byte returned by the engine with eng_ack |

## Verification
The assertions assume that eng_ack is a single-cycle pulse given only while req_valid is high, and that the receiver holds rx_valid and rx_data until rx_ready takes them. The bench's engine model acknowledges only a pending request, after a fixed two-cycle delay, and drops the acknowledge on the next cycle. Its send task keeps each byte on rx_data until the handshake edge. Transmitter back-pressure is applied in one scenario so that the hold and drain properties are exercised with a non-empty queue.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;

  typedef enum logic [3:0] {
    OP_ENTER   = 4'd0,
    OP_LEAVE   = 4'd1,
    OP_WR_LO   = 4'd2,
    OP_WR_HI   = 4'd3,
    OP_RD_LO   = 4'd4,
    OP_RD_HI   = 4'd5,
    OP_PAGE    = 4'd6,
    OP_WR_DATA = 4'd7,
    OP_RD_DATA = 4'd8,
    OP_ERASE   = 4'd9,
    OP_LOCK    = 4'd10,
    OP_SIG     = 4'd11,
    OP_UNIV    = 4'd12
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPER, ST_EXEC, ST_EMIT, ST_ENG, ST_RPUSH, ST_FIN
  } disp_state_e;

  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_ERR = 8'h3F;
  localparam logic [7:0] CH_ESC = 8'h1B;
  localparam logic [7:0] BYTE_WIDE_DEV = 8'h86;
  localparam int SW_MAJ = 2;
  localparam int SW_MIN = 0;
  localparam int HW_MAJ = 1;
  localparam int HW_MIN = 0;

  function automatic logic [7:0] ascii_digit(input int n);
    return 8'h30 + 8'(n);
  endfunction

  function automatic logic dev_supported(input logic [7:0] d);
    case (d)
      8'h12, 8'h13, 8'h20, 8'h28, 8'h38,
      8'h40, 8'h41, 8'h48, 8'h86: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] operand_count(input logic [7:0] c);
    case (c)
      "A": return 2'd2;
      ":": return 2'd3;
      "T", "x", "y", "C", "c", "D", "l": return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] fixed_len(input logic [7:0] c);
    case (c)
      "S": return 4'd7;
      "V", "v": return 4'd2;
      "t": return 4'd8;
      "p": return 4'd1;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] id_char(input logic [3:0] i);
    case (i)
      4'd0: return "C";
      4'd1: return "M";
      4'd2: return "D";
      4'd3: return "P";
      4'd4: return "R";
      4'd5: return "O";
      default: return "G";
    endcase
  endfunction

  function automatic logic [7:0] dev_list(input logic [3:0] i);
    case (i)
      4'd0: return 8'h12;
      4'd1: return 8'h13;
      4'd2: return 8'h20;
      4'd3: return 8'h28;
      4'd4: return 8'h38;
      4'd5: return 8'h48;
      4'd6: return 8'h86;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixed_byte(input logic [7:0] c, input logic [3:0] i);
    case (c)
      "S": return id_char(i);
      "V": return (i == 4'd0) ? ascii_digit(SW_MAJ) : ascii_digit(SW_MIN);
      "v": return (i == 4'd0) ? ascii_digit(HW_MAJ) : ascii_digit(HW_MIN);
      "t": return dev_list(i);
      default: return "S";
    endcase
  endfunction

  function automatic logic is_engine_cmd(input logic [7:0] c);
    case (c)
      "P", "L", "c", "C", "R", "m", "D", "d", "e", "l", "s", ":": return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic refused(input logic [7:0] c, input logic [7:0] d);
    return !dev_supported(d) || (d == BYTE_WIDE_DEV && (c == "C" || c == "s"));
  endfunction

  function automatic logic [1:0] frame_count(input logic [7:0] c, input logic bw);
    case (c)
      "R": return bw ? 2'd1 : 2'd2;
      "s": return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  function automatic eng_op_e frame_op(input logic [7:0] c, input logic [1:0] f, input logic bw);
    case (c)
      "P": return OP_ENTER;
      "L": return OP_LEAVE;
      "c": return OP_WR_LO;
      "C": return OP_WR_HI;
      "R": return (bw || f != 2'd0) ? OP_RD_LO : OP_RD_HI;
      "m": return OP_PAGE;
      "D": return OP_WR_DATA;
      "d": return OP_RD_DATA;
      "e": return OP_ERASE;
      "l": return OP_LOCK;
      "s": return OP_SIG;
      default: return OP_UNIV;
    endcase
  endfunction

  function automatic logic returns_data(input eng_op_e op);
    return op inside {OP_RD_LO, OP_RD_HI, OP_RD_DATA, OP_SIG, OP_UNIV};
  endfunction

  function automatic logic ends_with_cr(input logic [7:0] c);
    return !(c == "R" || c == "d" || c == "s");
  endfunction

  function automatic logic bumps_addr(input logic [7:0] c, input logic bw);
    return (c == "C") || (c == "R" && !bw);
  endfunction

  function automatic logic [23:0] req_payload(input logic [7:0] c, input logic [1:0] f,
                                              input logic [23:0] opnd);
    if (c == ":") return opnd;
    if (c == "s") return {22'd0, 2'd2 - f};
    return {16'd0, opnd[7:0]};
  endfunction

endpackage

// File: rtl/prog_resp_fifo.sv
module prog_resp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         empty,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  assign pop       = out_valid && out_ready;
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = !empty;
  assign out_data  = mem[rp];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (pop)  rp <= ptr_next(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R14
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data)); // R14

endmodule

// File: rtl/prog_addr_ctr.sv
module prog_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load && !inc |=> $stable(q)); // R11

endmodule

// File: rtl/prog_cmd_dispatch.sv
module prog_cmd_dispatch
  import prog_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [7:0]        req_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [23:0]       req_data,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rdata
);

  disp_state_e st_q, st_d;
  logic [7:0]  cmd_q, cmd_d, dev_q, dev_d, rbuf_q, rbuf_d, fin_q, fin_d;
  logic [23:0] opnd_q, opnd_d;
  logic [1:0]  ocnt_q, ocnt_d, fidx_q, fidx_d;
  logic [3:0]  idx_q, idx_d;

  logic        rx_fire, byte_wide, frame_last, frame_done;
  logic        push, fifo_full, fifo_empty;
  logic [7:0]  push_data;
  logic        addr_load, addr_inc;
  logic [ADDR_W-1:0] addr_q;
  eng_op_e     cur_op;

  assign rx_fire    = rx_valid && rx_ready;
  assign byte_wide  = (dev_q == BYTE_WIDE_DEV);
  assign cur_op     = frame_op(cmd_q, fidx_q, byte_wide);
  assign frame_last = (fidx_q == frame_count(cmd_q, byte_wide) - 2'd1);

  assign rx_ready  = (st_q == ST_IDLE && fifo_empty) || (st_q == ST_OPER);
  assign req_valid = (st_q == ST_ENG);
  assign req_op    = cur_op;
  assign req_dev   = dev_q;
  assign req_addr  = addr_q;
  assign req_data  = req_payload(cmd_q, fidx_q, opnd_q);

  prog_resp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .full(fifo_full), .empty(fifo_empty),
    .out_valid(tx_valid), .out_data(tx_data), .out_ready(tx_ready)
  );

  prog_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load),
    .load_val(ADDR_W'(opnd_q[15:0])), .inc(addr_inc), .q(addr_q)
  );

  always_comb begin
    st_d = st_q;   cmd_d = cmd_q;   dev_d = dev_q;   opnd_d = opnd_q;
    ocnt_d = ocnt_q; idx_d = idx_q; fidx_d = fidx_q; rbuf_d = rbuf_q; fin_d = fin_q;
    push = 1'b0;   push_data = fin_q;
    addr_load = 1'b0; addr_inc = 1'b0; frame_done = 1'b0;
    case (st_q)
      ST_IDLE: if (rx_fire && rx_data != CH_ESC) begin
        cmd_d  = rx_data;
        opnd_d = '0;
        ocnt_d = operand_count(rx_data);
        st_d   = (operand_count(rx_data) == 2'd0) ? ST_EXEC : ST_OPER;
      end
      ST_OPER: if (rx_fire) begin
        opnd_d = {opnd_q[15:0], rx_data};
        ocnt_d = ocnt_q - 2'd1;
        if (ocnt_q == 2'd1) st_d = ST_EXEC;
      end
      ST_EXEC: begin
        idx_d = '0; fidx_d = '0; fin_d = CH_CR;
        if (cmd_q == "T") begin
          dev_d = opnd_q[7:0];
          st_d  = ST_FIN;
        end else if (cmd_q == "A") begin
          addr_load = 1'b1;
          st_d      = ST_FIN;
        end else if (cmd_q == "x" || cmd_q == "y") begin
          st_d = ST_FIN;
        end else if (fixed_len(cmd_q) != 4'd0) begin
          st_d = ST_EMIT;
        end else if (!is_engine_cmd(cmd_q) || refused(cmd_q, dev_q)) begin
          fin_d = CH_ERR;
          st_d  = ST_FIN;
        end else begin
          st_d = ST_ENG;
        end
      end
      ST_EMIT: if (!fifo_full) begin
        push      = 1'b1;
        push_data = fixed_byte(cmd_q, idx_q);
        idx_d     = idx_q + 4'd1;
        if (idx_q == fixed_len(cmd_q) - 4'd1) st_d = ST_IDLE;
      end
      ST_ENG: if (eng_ack) begin
        rbuf_d = eng_rdata;
        if (returns_data(cur_op)) st_d = ST_RPUSH;
        else                      frame_done = 1'b1;
      end
      ST_RPUSH: if (!fifo_full) begin
        push       = 1'b1;
        push_data  = rbuf_q;
        frame_done = 1'b1;
      end
      ST_FIN: if (!fifo_full) begin
        push = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (frame_done) begin
      if (frame_last) begin
        addr_inc = bumps_addr(cmd_q, byte_wide);
        st_d     = ends_with_cr(cmd_q) ? ST_FIN : ST_IDLE;
      end else begin
        fidx_d = fidx_q + 2'd1;
        st_d   = ST_ENG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cmd_q <= '0; dev_q <= '0; opnd_q <= '0;
      ocnt_q <= '0; idx_q <= '0; fidx_q <= '0; rbuf_q <= '0; fin_q <= CH_CR;
    end else begin
      st_q <= st_d; cmd_q <= cmd_d; dev_q <= dev_d; opnd_q <= opnd_d;
      ocnt_q <= ocnt_d; idx_q <= idx_d; fidx_q <= fidx_d; rbuf_q <= rbuf_d; fin_q <= fin_d;
    end
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> dev_supported(req_dev)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !eng_ack |=> req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data)); // R14
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid || req_valid) |-> !rx_ready); // R14
  AST_ESC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) rx_fire && st_q == ST_IDLE && rx_data == CH_ESC |=> st_q == ST_IDLE && !tx_valid); // R2
  AST_NO_INC_BYTE_WIDE: assert property (@(posedge clk) disable iff (!rst_n) req_valid && eng_ack && byte_wide && req_op == 4'(OP_RD_LO) |=> $stable(req_addr)); // R12

endmodule

// File: tb/prog_cmd_dispatch_test.sv
module prog_cmd_dispatch_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [7:0]  req_dev;
  logic [15:0] req_addr;
  logic [23:0] req_data;
  logic        eng_ack = 1'b0;
  logic [7:0]  eng_rdata = 8'h00;

  int nchk = 0, nfail = 0, cyc = 0, overlap = 0;
  bit stall = 1'b0;
  logic [7:0]  got [64];
  int          ngot = 0;
  logic [3:0]  e_op [16];
  logic [15:0] e_addr [16];
  logic [23:0] e_data [16];
  logic [7:0]  e_dev [16];
  int          neng = 0;
  int          edly = 0;

  always #2 clk = ~clk;

  prog_cmd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .req_valid(req_valid), .req_op(req_op), .req_dev(req_dev), .req_addr(req_addr),
    .req_data(req_data), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
  );

  function automatic logic [7:0] mdl(input logic [3:0] op, input logic [15:0] a, input logic [23:0] d);
    return a[7:0] ^ a[15:8] ^ {op, 4'hA} ^ d[7:0];
  endfunction

  // transmitter model and response capture
  always @(negedge clk) begin
    tx_ready = !stall || (cyc % 4 == 0);
    if (tx_valid && tx_ready && ngot < 64) begin
      got[ngot] = tx_data;
      ngot++;
    end
    if (tx_valid && rx_ready) overlap++;
  end

  // frame engine model
  always @(negedge clk) begin
    eng_ack = 1'b0;
    if (!rst_n) edly = 0;
    else if (req_valid) begin
      if (edly == 2) begin
        eng_ack   = 1'b1;
        eng_rdata = mdl(req_op, req_addr, req_data);
        if (neng < 16) begin
          e_op[neng] = req_op; e_addr[neng] = req_addr;
          e_data[neng] = req_data; e_dev[neng] = req_dev;
        end
        neng++;
        edly = 0;
      end else edly++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      nchk++; nfail++;
      $display("FAIL R14 watchdog actual=%0d expected<=60000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!rx_ready && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, "R14 idle timeout", n, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic issue(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3);
    ngot = 0; neng = 0;
    send(b0);
    if (n > 1) send(b1);
    if (n > 2) send(b2);
    if (n > 3) send(b3);
    wait_idle();
  endtask

  task automatic expect1(input string req, input logic [7:0] b);
    chk(ngot == 1, req, ngot, 1);
    chk(got[0] == b, req, got[0], b);
  endtask

  task automatic t_reset();
    chk(rx_ready == 1'b1, "R1 rx_ready", rx_ready, 1);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
  endtask

  task automatic t_gate();
    issue(1, "P", 0, 0, 0);          // R9 default target 0x00
    expect1("R9 enter refused", 8'h3F);
    chk(neng == 0, "R9 no request", neng, 0);
    issue(2, "T", 8'h55, 0, 0);      // R5
    expect1("R5 select", 8'h0D);
    issue(1, "e", 0, 0, 0);
    expect1("R9 erase refused", 8'h3F);
    issue(2, "T", 8'h41, 0, 0);
    issue(1, "e", 0, 0, 0);
    expect1("R9 0x41 accepted", 8'h0D);
    chk(neng == 1 && e_op[0] == 4'd9, "R10 erase op", e_op[0], 9);
  endtask

  task automatic t_esc_ident();
    ngot = 0; neng = 0;
    send(8'h1B);
    repeat (4) @(negedge clk);
    chk(ngot == 0 && rx_ready, "R2 esc silent", ngot, 0);
    issue(1, "p", 0, 0, 0);
    expect1("R2 R7 type", 8'h53);
    issue(1, "V", 0, 0, 0);
    chk(ngot == 2 && got[0] == 8'h32 && got[1] == 8'h30, "R6 sw", {got[0], got[1]}, 16'h3230);
    issue(1, "v", 0, 0, 0);
    chk(ngot == 2 && got[0] == 8'h31 && got[1] == 8'h30, "R6 hw", {got[0], got[1]}, 16'h3130);
    issue(1, "t", 0, 0, 0);
    chk(ngot == 8, "R7 list len", ngot, 8);
    chk({got[0], got[1], got[2], got[3]} == 32'h12132028, "R7 list a",
        {got[0], got[1], got[2], got[3]}, 32'h12132028);
    chk({got[4], got[5], got[6], got[7]} == 32'h38488600, "R7 list b",
        {got[4], got[5], got[6], got[7]}, 32'h38488600);
    issue(1, "F", 0, 0, 0);
    expect1("R3 unknown", 8'h3F);
  endtask

  task automatic t_stall_id();
    ngot = 0; overlap = 0; stall = 1'b1;
    send("S");
    repeat (3) @(negedge clk);
    chk(rx_ready == 1'b0, "R14 busy while queued", rx_ready, 0);
    wait_idle();
    stall = 1'b0;
    chk(ngot == 7, "R7 id len", ngot, 7);
    chk({got[0], got[1], got[2], got[3]} == "CMDP", "R7 id a",
        {got[0], got[1], got[2], got[3]}, "CMDP");
    chk({got[4], got[5], got[6]} == "ROG", "R7 id b", {got[4], got[5], got[6]}, "ROG");
    chk(overlap == 0, "R14 overlap", overlap, 0);
  endtask

  task automatic t_noop();
    issue(2, "x", "V", 0, 0);
    expect1("R8 x operand", 8'h0D);
    issue(2, "y", 8'h1B, 0, 0);
    expect1("R8 y esc operand", 8'h0D);
  endtask

  task automatic t_enter_write();
    issue(2, "T", 8'h38, 0, 0);
    issue(1, "P", 0, 0, 0);
    expect1("R10 enter", 8'h0D);
    chk(neng == 1 && e_op[0] == 4'd0 && e_dev[0] == 8'h38, "R10 enter op", e_op[0], 0);
    issue(3, "A", 8'h12, 8'h34, 0);
    expect1("R4 addr", 8'h0D);
    issue(2, "c", 8'hAB, 0, 0);
    expect1("R11 low write", 8'h0D);
    chk(e_op[0] == 4'd2 && e_addr[0] == 16'h1234 && e_data[0] == 24'hAB, "R4 R11 low req",
        e_addr[0], 16'h1234);
    issue(2, "c", 8'h01, 0, 0);
    chk(e_addr[0] == 16'h1234, "R11 no inc low", e_addr[0], 16'h1234);
    issue(2, "C", 8'hCD, 0, 0);
    chk(e_op[0] == 4'd3 && e_addr[0] == 16'h1234, "R11 high req", e_addr[0], 16'h1234);
    issue(2, "C", 8'hEF, 0, 0);
    chk(e_addr[0] == 16'h1235, "R11 inc after high", e_addr[0], 16'h1235);
  endtask

  task automatic t_misc_ops();
    issue(1, "L", 0, 0, 0);
    chk(ngot == 1 && got[0] == 8'h0D && e_op[0] == 4'd1, "R10 leave", e_op[0], 1);
    issue(1, "m", 0, 0, 0);
    chk(ngot == 1 && e_op[0] == 4'd6, "R10 page", e_op[0], 6);
    issue(2, "D", 8'h5A, 0, 0);
    chk(ngot == 1 && e_op[0] == 4'd7 && e_data[0] == 24'h5A, "R10 data write", e_data[0], 24'h5A);
    issue(2, "l", 8'h06, 0, 0);
    chk(ngot == 1 && e_op[0] == 4'd10 && e_data[0] == 24'h06, "R10 lock", e_op[0], 10);
  endtask

  task automatic t_read();
    issue(3, "A", 8'h00, 8'hFF, 0);
    issue(1, "R", 0, 0, 0);
    chk(ngot == 2, "R12 read len", ngot, 2);
    chk(got[0] == mdl(5, 16'h00FF, 0), "R12 read high", got[0], mdl(5, 16'h00FF, 0));
    chk(got[1] == mdl(4, 16'h00FF, 0), "R12 read low", got[1], mdl(4, 16'h00FF, 0));
    chk(neng == 2 && e_op[0] == 4'd5 && e_op[1] == 4'd4, "R12 read ops", e_op[1], 4);
    issue(1, "d", 0, 0, 0);
    expect1("R12 data read after inc", mdl(8, 16'h0100, 0));
    issue(1, "s", 0, 0, 0);
    chk(ngot == 3 && got[0] == mdl(11, 16'h0100, 2) && got[1] == mdl(11, 16'h0100, 1)
        && got[2] == mdl(11, 16'h0100, 0), "R13 signature", got[0], mdl(11, 16'h0100, 2));
    chk(e_data[0] == 24'd2 && e_data[2] == 24'd0, "R13 sig index", e_data[2], 0);
    issue(4, ":", 8'h11, 8'h22, 8'h33);
    chk(ngot == 2 && got[0] == mdl(12, 16'h0100, 24'h112233) && got[1] == 8'h0D,
        "R13 universal", got[0], mdl(12, 16'h0100, 24'h112233));
    chk(e_data[0] == 24'h112233, "R13 universal operands", e_data[0], 24'h112233);
  endtask

  task automatic t_byte_wide();
    issue(2, "T", 8'h86, 0, 0);
    issue(3, "A", 8'h00, 8'h40, 0);
    issue(1, "R", 0, 0, 0);
    expect1("R12 byte-wide read", mdl(4, 16'h0040, 0));
    chk(neng == 1 && e_op[0] == 4'd4, "R12 byte-wide op", e_op[0], 4);
    issue(1, "R", 0, 0, 0);
    chk(e_addr[0] == 16'h0040, "R12 byte-wide no inc", e_addr[0], 16'h0040);
    issue(2, "C", 8'h01, 0, 0);
    expect1("R13 high write refused", 8'h3F);
    chk(neng == 0, "R13 no request", neng, 0);
    issue(1, "s", 0, 0, 0);
    expect1("R13 signature refused", 8'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_esc_ident();
    t_stall_id();
    t_noop();
    t_enter_write();
    t_misc_ops();
    t_read();
    t_byte_wide();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule